// File: doc/BRIEF.md
# Multipass Recycling Descriptor Queue

This block manages the shared descriptor buffer of a packet processor in which a packet is worked on in several short passes and not run to completion. Every stored descriptor holds an identifier tag and a count of the passes it still needs. Time advances in slots, and each slot starts on a one-cycle `slot_start` strobe. On that strobe the block does four things in a fixed order:

1. It settles the descriptors that the cores worked on in the previous slot. A descriptor with no passes left departs. A descriptor with passes left is appended to the tail of the queue.
2. It takes in the new arrivals, one port at a time.
3. It picks up to `CORES` descriptors from the head of the queue.
4. It hands those descriptors to the cores, and each one's residual count is lowered by one pass.

Admission is greedy while there is room. When the buffer is full, a new descriptor can displace a stored one only if the new descriptor needs strictly fewer passes than the largest residual count in the queue. The displaced entry is the oldest entry in queue order that holds that largest count. Every descriptor that is thrown away, whether it was stored or just arriving, is reported on the drop strobe of the arrival port that caused it. Finished descriptors are reported on the departure strobe of the core that ran them.

All results appear on registered one-cycle strobes in the cycle after `slot_start`. The block stores no payload and does not model the cores.

Top module: `mpq_mgr`

## Requirements
- R1: After reset the buffer is empty, and `gnt_valid`, `dep_valid` and `drop_valid` are all low.
- R2: In each slot, core c (c counting from 0) is granted the c-th descriptor from the head of the queue. The grant is made only if at least c+1 descriptors are queued, so grants always fill the low core indices first. Each grant shows the descriptor's tag and its residual pass count before the pass.
- R3: The buffer holds at most `DEPTH` descriptors. An arrival that finds fewer than `DEPTH` entries in the queue is always accepted at the tail and causes no drop.
- R4: An arrival that finds the buffer full is compared with the first entry, in queue order, that holds the largest residual count. If the arrival's pass count is strictly smaller, that entry is removed, the arrival goes to the tail, and the drop strobe of that port reports the removed entry's tag.
- R5: An arrival that finds the buffer full and whose pass count is equal to or greater than the largest residual count is rejected, and the drop strobe of that port reports the arrival's own tag.
- R6: A descriptor granted with residual count 1 departs at the next slot. It is reported on `dep_valid[c]` and `dep_id` of the core c that ran it, and no granted residual count is ever 0.
- R7: A granted descriptor with passes left goes back to the tail at the next slot, in core-index order, ahead of all arrivals of that slot.
- R8: Arrivals in one slot are handled in port order, port 0 first. Each is judged against the buffer as the earlier ports left it.
- R9: Grant, departure and drop strobes are high only in the cycle after a cycle with `slot_start` high, and each lasts one cycle.
- R10: Inputs on the arrival ports in a cycle without `slot_start` are ignored. They cause no strobe, and no later grant or drop shows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slot_start | input | 1 | One-cycle strobe that runs one time slot |
| arr_valid | input | ARR_N | Arrival present on each port |
| arr_id | input | ARR_N*ID_W | Arrival tags, port a in bits [a*ID_W +: ID_W] |
| arr_pass | input | ARR_N*PASS_W | Required pass counts (1..KMAX), port a in bits [a*PASS_W +: PASS_W] |
| gnt_valid | output | CORES | Core c is given a descriptor this slot |
| gnt_id | output | CORES*ID_W | Tag of the descriptor granted to each core |
| gnt_pass | output | CORES*PASS_W | Residual count of each granted descriptor before its pass |
| dep_valid | output | CORES | A descriptor run by core c has finished |
| dep_id | output | CORES*ID_W | Tag of each finished descriptor |
| drop_valid | output | ARR_N | Arrival port a caused a drop |
| drop_id | output | ARR_N*ID_W | Tag of the dropped descriptor for each port |

## Verification
The bench first uses sparse single arrivals. These separate the tail-append of recycled descriptors from the handling of new arrivals, and they show departures landing on the correct core index. Next it fills the buffer with equal large pass counts so that many entries share the maximum. Arrivals with smaller, equal and larger counts then separate eviction of the first holder of the maximum from eviction of a later holder, and strict comparison from non-strict comparison. Pairs of full-buffer arrivals in the same slot show whether port 1 sees the state that port 0 left. A long stretch of pseudo-random arrivals with irregular gaps between slots checks that the queue order stays correct over time, and arrivals driven outside a slot confirm that they are ignored.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
  localparam int MPQ_KMAX   = 16;
  localparam int MPQ_PASS_W = $clog2(MPQ_KMAX + 1);
  localparam int MPQ_ID_W   = 4;

  typedef struct packed {
    logic [MPQ_ID_W-1:0]   id;
    logic [MPQ_PASS_W-1:0] pass;
  } mpq_ent_t;
endpackage

// File: rtl/mpq_recycle.sv
// Transmission phase: retire finished in-flight entries, re-queue the rest.
module mpq_recycle
  import mpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CORES = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  mpq_ent_t             q_i [DEPTH],
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [CORES-1:0]     fl_vld_i,
  input  mpq_ent_t             fl_i [CORES],
  output mpq_ent_t             q_o [DEPTH],
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CORES-1:0]     dep_vld_o,
  output logic [MPQ_ID_W-1:0]  dep_id_o [CORES]
);
  logic [CNT_W-1:0] cnt_v;

  always_comb begin
    q_o       = q_i;
    cnt_v     = cnt_i;
    dep_vld_o = '0;
    for (int c = 0; c < CORES; c++) begin
      dep_id_o[c] = '0;
      if (fl_vld_i[c]) begin
        if (fl_i[c].pass == '0) begin
          dep_vld_o[c] = 1'b1;
          dep_id_o[c]  = fl_i[c].id;
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) == cnt_v) q_o[i] = fl_i[c];
          end
          cnt_v = cnt_v + CNT_W'(1);
        end
      end
    end
    cnt_o = cnt_v;
  end
endmodule

// File: rtl/mpq_admit.sv
// Arrival phase for one port: accept, evict-first-max, or reject.
module mpq_admit
  import mpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  mpq_ent_t             q_i [DEPTH],
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 a_vld_i,
  input  mpq_ent_t             a_ent_i,
  output mpq_ent_t             q_o [DEPTH],
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 drop_vld_o,
  output logic [MPQ_ID_W-1:0]  drop_id_o
);
  logic [MPQ_PASS_W-1:0] best;
  logic [IDX_W-1:0]      bidx;
  logic [MPQ_ID_W-1:0]   best_id;
  logic                  full;

  // Locate the earliest entry with the largest residual count.
  always_comb begin
    best    = '0;
    bidx    = '0;
    best_id = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < cnt_i) && (q_i[i].pass > best)) begin
        best    = q_i[i].pass;
        bidx    = IDX_W'(i);
        best_id = q_i[i].id;
      end
    end
  end

  assign full = (cnt_i >= CNT_W'(DEPTH));

  always_comb begin
    q_o        = q_i;
    cnt_o      = cnt_i;
    drop_vld_o = 1'b0;
    drop_id_o  = '0;
    if (a_vld_i) begin
      if (!full) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (CNT_W'(i) == cnt_i) q_o[i] = a_ent_i;
        end
        cnt_o = cnt_i + CNT_W'(1);
      end else if (a_ent_i.pass < best) begin
        drop_vld_o = 1'b1;
        drop_id_o  = best_id;
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (IDX_W'(i) >= bidx) q_o[i] = q_i[i+1];
        end
        q_o[DEPTH-1] = a_ent_i;
      end else begin
        drop_vld_o = 1'b1;
        drop_id_o  = a_ent_i.id;
      end
    end
  end
endmodule

// File: rtl/mpq_issue.sv
// Scheduling phase: take up to CORES entries from the head.
module mpq_issue
  import mpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CORES = 2,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  mpq_ent_t          q_i [DEPTH],
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CORES-1:0]  gnt_vld_o,
  output mpq_ent_t          gnt_o [CORES],
  output mpq_ent_t          q_o [DEPTH],
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] n_take;

  assign n_take = (cnt_i < CNT_W'(CORES)) ? cnt_i : CNT_W'(CORES);
  assign cnt_o  = cnt_i - n_take;

  always_comb begin
    for (int c = 0; c < CORES; c++) begin
      gnt_vld_o[c] = (CNT_W'(c) < cnt_i);
      gnt_o[c]     = q_i[c];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) q_o[i] = '0;
    for (int s = 0; s <= CORES; s++) begin
      if (n_take == CNT_W'(s)) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (i + s < DEPTH) q_o[i] = q_i[i+s];
        end
      end
    end
  end
endmodule

// File: rtl/mpq_mgr.sv
module mpq_mgr
  import mpq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CORES = 2,
  parameter int ARR_N = 2,
  localparam int ID_W   = MPQ_ID_W,
  localparam int PASS_W = MPQ_PASS_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    slot_start,
  input  logic [ARR_N-1:0]        arr_valid,
  input  logic [ARR_N*ID_W-1:0]   arr_id,
  input  logic [ARR_N*PASS_W-1:0] arr_pass,
  output logic [CORES-1:0]        gnt_valid,
  output logic [CORES*ID_W-1:0]   gnt_id,
  output logic [CORES*PASS_W-1:0] gnt_pass,
  output logic [CORES-1:0]        dep_valid,
  output logic [CORES*ID_W-1:0]   dep_id,
  output logic [ARR_N-1:0]        drop_valid,
  output logic [ARR_N*ID_W-1:0]   drop_id
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // State
  mpq_ent_t         q_r [DEPTH];
  logic [CNT_W-1:0] cnt_r;
  logic [CORES-1:0] fl_vld_r;
  mpq_ent_t         fl_r [CORES];

  // Phase 1: transmission
  mpq_ent_t         stg_q   [ARR_N+1][DEPTH];
  logic [CNT_W-1:0] stg_cnt [ARR_N+1];
  logic [CORES-1:0] rc_dep_vld;
  logic [ID_W-1:0]  rc_dep_id [CORES];

  mpq_recycle #(.DEPTH(DEPTH), .CORES(CORES), .CNT_W(CNT_W)) u_recycle (
    .q_i       (q_r),
    .cnt_i     (cnt_r),
    .fl_vld_i  (fl_vld_r),
    .fl_i      (fl_r),
    .q_o       (stg_q[0]),
    .cnt_o     (stg_cnt[0]),
    .dep_vld_o (rc_dep_vld),
    .dep_id_o  (rc_dep_id)
  );

  // Phase 2: arrivals, chained in port order
  mpq_ent_t         arr_ent [ARR_N];
  logic [ARR_N-1:0] ad_drop_vld;
  logic [ID_W-1:0]  ad_drop_id [ARR_N];

  for (genvar a = 0; a < ARR_N; a++) begin : g_admit
    assign arr_ent[a] = '{id: arr_id[a*ID_W +: ID_W], pass: arr_pass[a*PASS_W +: PASS_W]};

    mpq_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
      .q_i        (stg_q[a]),
      .cnt_i      (stg_cnt[a]),
      .a_vld_i    (arr_valid[a]),
      .a_ent_i    (arr_ent[a]),
      .q_o        (stg_q[a+1]),
      .cnt_o      (stg_cnt[a+1]),
      .drop_vld_o (ad_drop_vld[a]),
      .drop_id_o  (ad_drop_id[a])
    );
  end

  // Phase 3: scheduling
  logic [CORES-1:0] iss_vld;
  mpq_ent_t         iss_gnt [CORES];
  mpq_ent_t         q_nxt [DEPTH];
  logic [CNT_W-1:0] cnt_nxt;

  mpq_issue #(.DEPTH(DEPTH), .CORES(CORES), .CNT_W(CNT_W)) u_issue (
    .q_i       (stg_q[ARR_N]),
    .cnt_i     (stg_cnt[ARR_N]),
    .gnt_vld_o (iss_vld),
    .gnt_o     (iss_gnt),
    .q_o       (q_nxt),
    .cnt_o     (cnt_nxt)
  );

  // Phase 4: processing, plus next values of the output strobes
  mpq_ent_t                fl_nxt [CORES];
  logic [CORES-1:0]        gnt_v_nxt, dep_v_nxt;
  logic [CORES*ID_W-1:0]   gnt_id_nxt, dep_id_nxt;
  logic [CORES*PASS_W-1:0] gnt_p_nxt;
  logic [ARR_N-1:0]        drop_v_nxt;
  logic [ARR_N*ID_W-1:0]   drop_id_nxt;

  always_comb begin
    gnt_v_nxt   = '0;
    gnt_id_nxt  = '0;
    gnt_p_nxt   = '0;
    dep_v_nxt   = '0;
    dep_id_nxt  = '0;
    drop_v_nxt  = '0;
    drop_id_nxt = '0;
    for (int c = 0; c < CORES; c++) begin
      fl_nxt[c]      = iss_gnt[c];
      fl_nxt[c].pass = iss_gnt[c].pass - PASS_W'(1);
    end
    if (slot_start) begin
      gnt_v_nxt  = iss_vld;
      dep_v_nxt  = rc_dep_vld;
      drop_v_nxt = ad_drop_vld;
      for (int c = 0; c < CORES; c++) begin
        gnt_id_nxt[c*ID_W +: ID_W]     = iss_gnt[c].id;
        gnt_p_nxt[c*PASS_W +: PASS_W]  = iss_gnt[c].pass;
        dep_id_nxt[c*ID_W +: ID_W]     = rc_dep_id[c];
      end
      for (int a = 0; a < ARR_N; a++) begin
        drop_id_nxt[a*ID_W +: ID_W] = ad_drop_id[a];
      end
    end
  end

  // Buffer state registers, enabled by the slot strobe
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int i = 0; i < DEPTH; i++) q_r[i] <= '0;
      for (int c = 0; c < CORES; c++) fl_r[c] <= '0;
      cnt_r    <= '0;
      fl_vld_r <= '0;
    end else if (slot_start) begin
      q_r      <= q_nxt;
      cnt_r    <= cnt_nxt;
      fl_vld_r <= iss_vld;
      fl_r     <= fl_nxt;
    end
  end

  // Output strobe registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      gnt_valid  <= '0;
      gnt_id     <= '0;
      gnt_pass   <= '0;
      dep_valid  <= '0;
      dep_id     <= '0;
      drop_valid <= '0;
      drop_id    <= '0;
    end else begin
      gnt_valid  <= gnt_v_nxt;
      gnt_id     <= gnt_id_nxt;
      gnt_pass   <= gnt_p_nxt;
      dep_valid  <= dep_v_nxt;
      dep_id     <= dep_id_nxt;
      drop_valid <= drop_v_nxt;
      drop_id    <= drop_id_nxt;
    end
  end
endmodule

// File: rtl/mpq_mgr_chk.sv
module mpq_mgr_chk #(
  parameter int DEPTH  = 8,
  parameter int CORES  = 2,
  parameter int ARR_N  = 2,
  parameter int PASS_W = 5,
  parameter int CNT_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    slot_start,
  input logic [ARR_N-1:0]        arr_valid,
  input logic [CORES-1:0]        gnt_valid,
  input logic [CORES*PASS_W-1:0] gnt_pass,
  input logic [CORES-1:0]        dep_valid,
  input logic [ARR_N-1:0]        drop_valid,
  input logic [CNT_W-1:0]        occ
);
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  p_gnt_after_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_valid) |-> $past(slot_start));

  p_dep_after_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|dep_valid) |-> $past(slot_start));

  p_occ_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable(occ));

  for (genvar c = 0; c < CORES; c++) begin : g_core
    p_gnt_pass_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid[c] |-> (gnt_pass[c*PASS_W +: PASS_W] != '0));
    if (c > 0) begin : g_pack
      p_gnt_packed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid[c] |-> gnt_valid[c-1]);
    end
  end

  for (genvar a = 0; a < ARR_N; a++) begin : g_port
    p_drop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      drop_valid[a] |-> $past(arr_valid[a] && slot_start));
  end
endmodule

bind mpq_mgr mpq_mgr_chk #(
  .DEPTH(DEPTH), .CORES(CORES), .ARR_N(ARR_N), .PASS_W(PASS_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_start (slot_start),
  .arr_valid  (arr_valid),
  .gnt_valid  (gnt_valid),
  .gnt_pass   (gnt_pass),
  .dep_valid  (dep_valid),
  .drop_valid (drop_valid),
  .occ        (cnt_r)
);

// File: tb/tb_mpq_mgr.sv
`timescale 1ns/1ps
module tb_mpq_mgr;
  localparam int DEPTH = 8;
  localparam int CORES = 2;
  localparam int ARR_N = 2;
  localparam int ID_W  = 4;
  localparam int PW    = 5;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  slot_start;
  logic [ARR_N-1:0]      arr_valid;
  logic [ARR_N*ID_W-1:0] arr_id;
  logic [ARR_N*PW-1:0]   arr_pass;
  logic [CORES-1:0]      gnt_valid, dep_valid;
  logic [CORES*ID_W-1:0] gnt_id, dep_id;
  logic [CORES*PW-1:0]   gnt_pass;
  logic [ARR_N-1:0]      drop_valid;
  logic [ARR_N*ID_W-1:0] drop_id;

  always #10 clk = ~clk;

  mpq_mgr #(.DEPTH(DEPTH), .CORES(CORES), .ARR_N(ARR_N)) dut (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .arr_valid(arr_valid), .arr_id(arr_id), .arr_pass(arr_pass),
    .gnt_valid(gnt_valid), .gnt_id(gnt_id), .gnt_pass(gnt_pass),
    .dep_valid(dep_valid), .dep_id(dep_id),
    .drop_valid(drop_valid), .drop_id(drop_id)
  );

  typedef struct { int id; int pass; } tent_t;
  typedef struct {
    logic [CORES-1:0]      gv;
    logic [CORES*ID_W-1:0] gid;
    logic [CORES*PW-1:0]   gp;
    logic [CORES-1:0]      dv;
    logic [CORES*ID_W-1:0] did;
    logic [ARR_N-1:0]      xv;
    logic [ARR_N*ID_W-1:0] xid;
    string                 tag;
  } snap_t;

  tent_t mq[$];
  tent_t fl[$];
  snap_t sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    next_id = 0;
  bit    seen = 1'b0;
  bit    done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // Driver: expected results from the requirements, then one slot strobe.
  task automatic run_slot(input logic [1:0] av, input int p0, input int p1, input string tag);
    snap_t s;
    tent_t e;
    int    ids[2];
    int    ps[2];
    ps[0] = p0; ps[1] = p1;
    s.gv = '0; s.gid = '0; s.gp = '0; s.dv = '0; s.did = '0; s.xv = '0; s.xid = '0;
    s.tag = tag;
    for (int c = 0; c < fl.size(); c++) begin
      if (fl[c].pass == 0) begin
        s.dv[c] = 1'b1;
        s.did[c*ID_W +: ID_W] = 4'(fl[c].id);
      end else mq.push_back(fl[c]);
    end
    fl.delete();
    for (int a = 0; a < ARR_N; a++) begin
      ids[a] = next_id % 16;
      if (av[a]) begin
        next_id++;
        e.id = ids[a]; e.pass = ps[a];
        if (mq.size() < DEPTH) mq.push_back(e);
        else begin
          int mx = 0; int mi = 0;
          for (int i = 0; i < mq.size(); i++)
            if (mq[i].pass > mx) begin mx = mq[i].pass; mi = i; end
          s.xv[a] = 1'b1;
          if (e.pass < mx) begin
            s.xid[a*ID_W +: ID_W] = 4'(mq[mi].id);
            mq.delete(mi);
            mq.push_back(e);
          end else s.xid[a*ID_W +: ID_W] = 4'(e.id);
        end
      end
    end
    for (int c = 0; c < CORES; c++) begin
      if (mq.size() > 0) begin
        e = mq.pop_front();
        s.gv[c] = 1'b1;
        s.gid[c*ID_W +: ID_W] = 4'(e.id);
        s.gp[c*PW +: PW]      = 5'(e.pass);
        e.pass--;
        fl.push_back(e);
      end
    end
    sb.push_back(s);
    slot_start = 1'b1;
    arr_valid  = av;
    arr_id     = {4'(ids[1]), 4'(ids[0])};
    arr_pass   = {5'(p1), 5'(p0)};
    @(negedge clk);
    slot_start = 1'b0;
    arr_valid  = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per slot and compares it.
  always @(posedge clk) seen <= rst_n && slot_start;

  always @(negedge clk) begin : mon
    snap_t s;
    logic [CORES*ID_W-1:0] ag, ad;
    logic [CORES*PW-1:0]   ap;
    logic [ARR_N*ID_W-1:0] ax;
    if (rst_n && !done) begin
      if (seen) begin
        n_chk++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R9 strobe slot without expected item: actual gv=%b expected none", gnt_valid);
        end else begin
          s = sb.pop_front();
          ag = '0; ad = '0; ap = '0; ax = '0;
          for (int c = 0; c < CORES; c++) begin
            if (gnt_valid[c]) begin
              ag[c*ID_W +: ID_W] = gnt_id[c*ID_W +: ID_W];
              ap[c*PW +: PW]     = gnt_pass[c*PW +: PW];
            end
            if (dep_valid[c]) ad[c*ID_W +: ID_W] = dep_id[c*ID_W +: ID_W];
          end
          for (int a = 0; a < ARR_N; a++)
            if (drop_valid[a]) ax[a*ID_W +: ID_W] = drop_id[a*ID_W +: ID_W];
          if (gnt_valid !== s.gv || ag !== s.gid || ap !== s.gp) begin
            n_bad++;
            $display("FAIL R2 [%s] grants: actual v=%b id=%h p=%h expected v=%b id=%h p=%h",
                     s.tag, gnt_valid, ag, ap, s.gv, s.gid, s.gp);
          end
          n_chk++;
          if (dep_valid !== s.dv || ad !== s.did) begin
            n_bad++;
            $display("FAIL R6 [%s] departures: actual v=%b id=%h expected v=%b id=%h",
                     s.tag, dep_valid, ad, s.dv, s.did);
          end
          n_chk++;
          if (drop_valid !== s.xv || ax !== s.xid) begin
            n_bad++;
            $display("FAIL R4/R5 [%s] drops: actual v=%b id=%h expected v=%b id=%h",
                     s.tag, drop_valid, ax, s.xv, s.xid);
          end
        end
      end else begin
        n_chk++;
        if (|{gnt_valid, dep_valid, drop_valid}) begin
          n_bad++;
          $display("FAIL R9 R10 strobe outside slot: actual g=%b d=%b x=%b expected 0",
                   gnt_valid, dep_valid, drop_valid);
        end
      end
    end
  end

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; slot_start = 1'b0; arr_valid = '0; arr_id = '0; arr_pass = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    n_chk++;
    if (|{gnt_valid, dep_valid, drop_valid}) begin
      n_bad++;
      $display("FAIL R1 reset strobes: actual %b expected 0", {gnt_valid, dep_valid, drop_valid});
    end
    run_slot(2'b00, 1, 1, "R1 R9 empty slot");
    idle(2);
    // R2 R6: single short descriptor
    run_slot(2'b01, 1, 1, "R2 R3 single");
    run_slot(2'b00, 1, 1, "R6 depart");
    // R7: recycling ahead of new arrivals
    run_slot(2'b11, 2, 3, "R7 pair");
    run_slot(2'b01, 1, 1, "R7 recycle before arrival");
    for (int i = 0; i < 8; i++) run_slot(2'b00, 1, 1, "R6 R7 drain");
    // R10: arrivals outside slots
    arr_valid = 2'b11; arr_id = 8'hFF; arr_pass = {5'd1, 5'd1};
    idle(3);
    arr_valid = '0;
    run_slot(2'b00, 1, 1, "R10 ignored");
    // R3 R4 R5 R8: fill to full with equal large counts
    for (int i = 0; i < 5; i++) run_slot(2'b11, 16, 16, "R3 fill");
    run_slot(2'b01, 16, 1, "R5 equal rejected");
    run_slot(2'b01, 3, 1, "R4 first max evicted");
    run_slot(2'b11, 2, 4, "R8 two evictions");
    run_slot(2'b11, 16, 15, "R5 R8 larger rejected");
    for (int i = 0; i < 40; i++) run_slot(2'b00, 1, 1, "R6 R7 drain");
    // Pseudo-random traffic with irregular gaps
    for (int i = 0; i < 500; i++) begin
      step_lfsr();
      run_slot(lfsr[1:0], int'(lfsr[5:2]) + 1, int'(lfsr[9:6]) + 1, "R2 R4 R5 R7 R8 random");
      if (lfsr[11]) idle(int'(lfsr[13:12]));
    end
    for (int i = 0; i < 80; i++) run_slot(2'b00, 1, 1, "R6 final drain");
    idle(3);
    done = 1'b1;
    n_chk++;
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL R9 pending items: actual %0d expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule